// File: doc/BRIEF.md
# Dual-Clock FIFO with Rewind Replay

This block is a first-in first-out buffer that moves words from a write clock domain into an unrelated read clock domain. Each side keeps a binary pointer one bit wider than the address. Each side also keeps a Gray copy of its pointer, and that copy crosses to the other side through a two-flop synchroniser. The read side derives the registered empty flag and the write side derives the registered full flag. Both flags are active low. Reads use standard timing: a word appears on the read data output only after a read clock edge on which read enable is high and the FIFO is not empty.

A replay request moves the read pointer back to memory location zero, so that every word written since the last reset can be read out a second time. The request is taken on a read clock edge while the active-low replay input is low. For a fixed setup period of two read clock cycles, the empty flag is held asserted. After that, the flag is computed again from the rewound pointer, and each replayed word again needs its own read enable. The request is honoured only when the session is in a safe state. A master reset clears the pointers and the read data register. A partial reset clears only the pointers.

Top module: `fifo_rt`

## Requirements
- R1: After master reset, empty_no is low, full_no is high and rdata_o is all zeros.
- R2: Words leave in the order they were written. rdata_o takes the next word on the read clock edge where rd_en_i is high and empty_no is high (deasserted). Once every written word has been read, empty_no goes low.
- R3: With DEPTH unread words held, full_no is low. Write attempts while full_no is low store nothing, so only the first DEPTH words are read back.
- R4: A read attempt while empty_no is low changes neither rdata_o nor the read pointer.
- R5: Replay is accepted when retx_ni is low on a read clock edge and all of the following hold: rd_en_i and wr_en_i are both low, and R7's qualification holds. On acceptance, empty_no is low for exactly the two read clock cycles after that edge. It is then recomputed, and the next reads return the words from location zero onward.
- R6: A replay request made while rd_en_i or wr_en_i is high is ignored. A read on that edge proceeds normally, and the sequence continues from the current position.
- R7: A replay request is ignored in either of two cases. The first is that fewer than two words were read since the last reset or accepted replay. The second is that more than DEPTH-2 words were read since then, or written since the last reset.
- R8: A partial reset empties the FIFO (empty_no low, full_no high) and leaves rdata_o unchanged. A master reset also clears rdata_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Master reset, asynchronous, active low |
| part_rst_ni | input | 1 | Partial reset (pointers only), asynchronous, active low |
| wr_en_i | input | 1 | Write enable, active high |
| wdata_i | input | DW | Write data |
| rd_en_i | input | 1 | Read enable, active high |
| retx_ni | input | 1 | Replay request, active low, sampled on rclk_i |
| rdata_o | output | DW | Registered read data |
| empty_no | output | 1 | Empty flag, low when empty or during replay setup |
| full_no | output | 1 | Full flag, low when full |

## Verification
The bench targets the following corner cases:
- **Setup window length.** The bench checks the width of the replay setup window edge by edge. A design that forces empty for one cycle or three would show the flag rising early or late.
- **Replay refused under enable.** A request made under read enable must be refused. A design that ignored that rule would return the first word again instead of the next one.
- **Too few reads.** A request after only one read must be refused.
- **Too many writes.** A request after more than DEPTH-2 writes must be refused. A design with a broken qualification would restart the sequence in either case.
- **Overflow and partial reset.** Overflowing the buffer exposes a pointer that advances past the full flag. A partial reset that wrongly clears the read data register shows up as a zeroed output.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  localparam int unsigned RT_SETUP_CYC = 2;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/fifo_rt_sync.sv
module fifo_rt_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/fifo_rt_mem.sv
module fifo_rt_mem #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fifo_rt_wr.sv
module fifo_rt_wr
  import fifo_rt_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic          wclk_i,
  input  logic          ptr_rst_ni,
  input  logic          wr_en_i,
  input  logic [AW:0]   rgray_s_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic          full_no,
  output logic          wr_over_o
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned PW    = AW + 1;

  logic [AW:0] wbin_q, wbin_nxt, wgray_q, wgray_nxt, full_cmp;
  logic        full_n_q, wr_over_q, wfire;

  assign wfire     = wr_en_i & full_n_q;
  assign wbin_nxt  = wbin_q + PW'(wfire);
  assign wgray_nxt = PW'(bin2gray(32'(wbin_nxt)));
  // full when write gray equals read gray with top two bits inverted
  assign full_cmp  = {~rgray_s_i[AW:AW-1], rgray_s_i[AW-2:0]};

  always_ff @(posedge wclk_i or negedge ptr_rst_ni) begin
    if (!ptr_rst_ni) begin
      wbin_q    <= '0;
      wgray_q   <= '0;
      full_n_q  <= 1'b1;
      wr_over_q <= 1'b0;
    end else begin
      wbin_q    <= wbin_nxt;
      wgray_q   <= wgray_nxt;
      full_n_q  <= (wgray_nxt != full_cmp);
      wr_over_q <= wr_over_q | (wfire && wbin_q == PW'(DEPTH - 2));
    end
  end

  assign we_o      = wfire;
  assign waddr_o   = wbin_q[AW-1:0];
  assign wgray_o   = wgray_q;
  assign full_no   = full_n_q;
  assign wr_over_o = wr_over_q;

  AST_NO_OVERFLOW: assert property (@(posedge wclk_i) disable iff (!ptr_rst_ni) (wr_en_i && !full_n_q) |=> $stable(wbin_q)); // R3
endmodule

// File: rtl/fifo_rt_rd.sv
module fifo_rt_rd
  import fifo_rt_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          ptr_rst_ni,
  input  logic          rd_en_i,
  input  logic          retx_ni,
  input  logic          wr_en_i,
  input  logic [AW:0]   wgray_s_i,
  input  logic          wr_over_s_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic [DW-1:0] rdata_o,
  output logic          empty_no
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned SCW   = $clog2(RT_SETUP_CYC + 1);

  logic [AW:0]    rbin_q, rbin_nxt, rgray_q, rgray_nxt;
  logic [SCW-1:0] setup_q;
  logic [DW-1:0]  rdata_q;
  logic           empty_n_q, empty_n_d, rd_over_q, rfire, rt_acc;

  assign rfire  = rd_en_i & empty_n_q;
  assign rt_acc = !retx_ni && !rd_en_i && !wr_en_i && (setup_q == '0) &&
                  (rbin_q >= PW'(2)) && !rd_over_q && !wr_over_s_i;

  assign rbin_nxt  = rt_acc ? '0 : rbin_q + PW'(rfire);
  assign rgray_nxt = PW'(bin2gray(32'(rbin_nxt)));
  // forced empty through the setup window, then normal compare
  assign empty_n_d = !(rt_acc || setup_q > SCW'(1)) && (rgray_nxt != wgray_s_i);

  always_ff @(posedge rclk_i or negedge ptr_rst_ni) begin
    if (!ptr_rst_ni) begin
      rbin_q    <= '0;
      rgray_q   <= '0;
      empty_n_q <= 1'b0;
      setup_q   <= '0;
      rd_over_q <= 1'b0;
    end else begin
      rbin_q    <= rbin_nxt;
      rgray_q   <= rgray_nxt;
      empty_n_q <= empty_n_d;
      if (rt_acc)              setup_q <= SCW'(RT_SETUP_CYC);
      else if (setup_q != '0)  setup_q <= setup_q - SCW'(1);
      rd_over_q <= rt_acc ? 1'b0 : (rd_over_q | (rfire && rbin_q == PW'(DEPTH - 2)));
    end
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rfire) rdata_q <= mem_rdata_i;
  end

  assign raddr_o  = rbin_q[AW-1:0];
  assign rgray_o  = rgray_q;
  assign rdata_o  = rdata_q;
  assign empty_no = empty_n_q;

  AST_NO_UNDERFLOW: assert property (@(posedge rclk_i) disable iff (!ptr_rst_ni) (rd_en_i && !empty_n_q) |=> ($stable(rbin_q) && $stable(rdata_q))); // R4
  AST_RT_REWIND: assert property (@(posedge rclk_i) disable iff (!ptr_rst_ni) rt_acc |=> (rbin_q == '0 && !empty_n_q)); // R5
  AST_RT_HOLD: assert property (@(posedge rclk_i) disable iff (!ptr_rst_ni) (setup_q == SCW'(RT_SETUP_CYC)) |=> (!empty_n_q && rbin_q == '0)); // R5
  AST_RT_REJECT: assert property (@(posedge rclk_i) disable iff (!ptr_rst_ni) (!retx_ni && (rd_en_i || wr_en_i) && setup_q == '0) |=> (setup_q == '0)); // R6
endmodule

// File: rtl/fifo_rt.sv
module fifo_rt #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          part_rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_en_i,
  input  logic          retx_ni,
  output logic [DW-1:0] rdata_o,
  output logic          empty_no,
  output logic          full_no
);
  logic          ptr_rst_n, we, wr_over, wr_over_s;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
  logic [DW-1:0] mem_rdata;

  assign ptr_rst_n = rst_ni & part_rst_ni;

  fifo_rt_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk_i(wclk_i), .we_i(we), .waddr_i(waddr), .wdata_i(wdata_i),
    .raddr_i(raddr), .rdata_o(mem_rdata)
  );

  fifo_rt_wr #(.AW(AW)) u_wr (
    .wclk_i(wclk_i), .ptr_rst_ni(ptr_rst_n), .wr_en_i(wr_en_i),
    .rgray_s_i(rgray_s), .we_o(we), .waddr_o(waddr), .wgray_o(wgray),
    .full_no(full_no), .wr_over_o(wr_over)
  );

  fifo_rt_sync #(.W(AW + 1)) u_w2r (
    .clk_i(rclk_i), .rst_ni(ptr_rst_n), .d_i(wgray), .q_o(wgray_s)
  );

  fifo_rt_sync #(.W(1)) u_over2r (
    .clk_i(rclk_i), .rst_ni(ptr_rst_n), .d_i(wr_over), .q_o(wr_over_s)
  );

  fifo_rt_sync #(.W(AW + 1)) u_r2w (
    .clk_i(wclk_i), .rst_ni(ptr_rst_n), .d_i(rgray), .q_o(rgray_s)
  );

  fifo_rt_rd #(.DW(DW), .AW(AW)) u_rd (
    .rclk_i(rclk_i), .rst_ni(rst_ni), .ptr_rst_ni(ptr_rst_n),
    .rd_en_i(rd_en_i), .retx_ni(retx_ni), .wr_en_i(wr_en_i),
    .wgray_s_i(wgray_s), .wr_over_s_i(wr_over_s), .mem_rdata_i(mem_rdata),
    .raddr_o(raddr), .rgray_o(rgray), .rdata_o(rdata_o), .empty_no(empty_no)
  );
endmodule

// File: tb/tb_fifo_rt.sv
module tb_fifo_rt;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic wclk = 1'b0, rclk = 1'b0;
  logic rst_n = 1'b0, prst_n = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, retx_n = 1'b1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic empty_n, full_n;
  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] d;
  logic e1, e2, e3;

  always #2 wclk = ~wclk;   // 250 MHz write clock
  always #3 rclk = ~rclk;

  fifo_rt #(.DW(DW), .AW(AW)) dut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .part_rst_ni(prst_n),
    .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en), .retx_ni(retx_n),
    .rdata_o(rdata), .empty_no(empty_n), .full_no(full_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [DW-1:0] v);
    @(negedge wclk); wr_en = 1'b1; wdata = v;
    @(negedge wclk); wr_en = 1'b0;
  endtask

  task automatic rd_word(output logic [DW-1:0] v);
    @(negedge rclk); rd_en = 1'b1;
    @(negedge rclk); rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
  endtask

  task automatic part_reset();
    @(negedge rclk); #1 prst_n = 1'b0;
    repeat (3) @(negedge rclk);
    #1 prst_n = 1'b1;
    settle();
  endtask

  task automatic retx_pulse(output logic a, output logic b, output logic c);
    @(negedge rclk); retx_n = 1'b0;
    @(negedge rclk); retx_n = 1'b1; a = empty_n;
    @(negedge rclk); b = empty_n;
    @(negedge rclk); c = empty_n;
  endtask

  initial begin
    repeat (100000) @(posedge wclk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge rclk);
    #1 rst_n = 1'b1;
    settle();
    // R1 reset state
    chk(empty_n == 1'b0, "R1 empty", empty_n, 0);
    chk(full_n == 1'b1, "R1 full", full_n, 1);
    chk(rdata == '0, "R1 rdata", rdata, 0);

    // R4 read while empty
    rd_word(d);
    chk(d == '0, "R4 rdata held", d, 0);
    chk(empty_n == 1'b0, "R4 still empty", empty_n, 0);

    // R2 ordering
    for (int i = 0; i < 5; i++) wr_word(8'h10 + 8'(i * 3));
    settle();
    chk(empty_n == 1'b1, "R2 not empty", empty_n, 1);
    for (int i = 0; i < 5; i++) begin
      rd_word(d);
      chk(d == 8'h10 + 8'(i * 3), "R2 order", d, 8'h10 + 8'(i * 3));
    end
    settle();
    chk(empty_n == 1'b0, "R2 drained", empty_n, 0);

    // R3 overflow: DEPTH+2 writes, last two dropped
    for (int i = 0; i < DEPTH + 2; i++) wr_word(8'h40 + 8'(i));
    settle();
    chk(full_n == 1'b0, "R3 full", full_n, 0);
    for (int i = 0; i < DEPTH; i++) begin
      rd_word(d);
      chk(d == 8'h40 + 8'(i), "R3 data", d, 8'h40 + 8'(i));
    end
    settle();
    chk(empty_n == 1'b0, "R3 empty after drain", empty_n, 0);
    chk(full_n == 1'b1, "R3 full cleared", full_n, 1);

    // R8 partial reset keeps rdata
    for (int i = 0; i < 3; i++) wr_word(8'h55);
    settle();
    part_reset();
    chk(rdata == 8'h47, "R8 rdata kept", rdata, 8'h47);
    chk(empty_n == 1'b0, "R8 empty", empty_n, 0);
    chk(full_n == 1'b1, "R8 not full", full_n, 1);
    rd_word(d);
    chk(d == 8'h47, "R8 nothing left", d, 8'h47);

    // R5 accepted replay
    for (int i = 0; i < 5; i++) wr_word(8'h60 + 8'(i));
    settle();
    for (int i = 0; i < 3; i++) begin
      rd_word(d);
      chk(d == 8'h60 + 8'(i), "R5 pre-read", d, 8'h60 + 8'(i));
    end
    chk(empty_n == 1'b1, "R5 words pending", empty_n, 1);
    retx_pulse(e1, e2, e3);
    chk(e1 == 1'b0, "R5 setup cycle 1", e1, 0);
    chk(e2 == 1'b0, "R5 setup cycle 2", e2, 0);
    chk(e3 == 1'b1, "R5 setup done", e3, 1);
    for (int i = 0; i < 5; i++) begin
      rd_word(d);
      chk(d == 8'h60 + 8'(i), "R5 replay", d, 8'h60 + 8'(i));
    end
    settle();
    chk(empty_n == 1'b0, "R5 drained", empty_n, 0);

    // R6 request under read enable ignored
    part_reset();
    for (int i = 0; i < 6; i++) wr_word(8'h80 + 8'(i));
    settle();
    for (int i = 0; i < 3; i++) rd_word(d);
    @(negedge rclk); retx_n = 1'b0; rd_en = 1'b1;
    @(negedge rclk); retx_n = 1'b1; rd_en = 1'b0;
    chk(rdata == 8'h83, "R6 read proceeds", rdata, 8'h83);
    chk(empty_n == 1'b1, "R6 no setup", empty_n, 1);
    rd_word(d);
    chk(d == 8'h84, "R6 no rewind", d, 8'h84);

    // R7 too few reads
    part_reset();
    for (int i = 0; i < 4; i++) wr_word(8'hA0 + 8'(i));
    settle();
    rd_word(d);
    retx_pulse(e1, e2, e3);
    chk(e1 && e2 && e3, "R7 few reads no setup", {e1, e2, e3}, 3'b111);
    rd_word(d);
    chk(d == 8'hA1, "R7 few reads no rewind", d, 8'hA1);

    // R7 too many writes
    part_reset();
    for (int i = 0; i < DEPTH - 1; i++) wr_word(8'hB0 + 8'(i));
    settle();
    rd_word(d); rd_word(d);
    retx_pulse(e1, e2, e3);
    chk(e1 && e2 && e3, "R7 many writes no setup", {e1, e2, e3}, 3'b111);
    rd_word(d);
    chk(d == 8'hB2, "R7 many writes no rewind", d, 8'hB2);

    // R8 master reset clears rdata
    @(negedge rclk); #1 rst_n = 1'b0;
    repeat (3) @(negedge rclk);
    #1 rst_n = 1'b1;
    settle();
    chk(rdata == '0, "R8 master clears rdata", rdata, 0);
    chk(empty_n == 1'b0, "R8 master empty", empty_n, 0);
    chk(full_n == 1'b1, "R8 master not full", full_n, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule